// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counting timer with a width of 24 bits. A processor reaches it through a small register port that completes each access in one cycle. Software loads a period value, picks the tick source and turns the counter on. The tick source is either every cycle of the core clock or a one-cycle pulse on an external reference input. Each time the count runs out, the block sets a sticky expiry flag. If the interrupt enable is set, it also sends a one-cycle pending request to the interrupt controller.

The register port has four word slots. Slot 0 is control and status, slot 1 is the period (reload) value, slot 2 is the live count and slot 3 is a read-only calibration constant. Two register accesses have side effects. Reading control clears the expiry flag. Writing the live count restarts the period. Turning the counter off freezes the count, and turning it back on continues from the frozen value. The exception is when no count is in progress: after reset, or after a zero period has stopped the timer, turning it on first loads the period.

Top module: `systick_timer`

## Requirements
- R1: After reset, control, reload and live count all read 0, calibration reads 10000, and irq_o and rvalid_o are low.
- R2: A read request (req_i high, we_i low) returns data on rdata_o, with rvalid_o high, in the cycle that follows. addr_i selects 0 control, 1 reload, 2 live count, 3 calibration.
- R3: In the control word, bit 0 is the enable, bit 1 is the interrupt enable, bit 2 is the source select (1 selects the core clock, 0 selects ref_tick_i) and bit 16 is the expiry flag. A write changes only bits 2:0, and software cannot write the flag.
- R4: Reload and live count are 24 bits wide. Bits 31:24 of a write are ignored, and those bits read as zero.
- R5: While enabled, the live count decreases by one on each cycle in which the selected tick is active, and on no other cycle.
- R6: A tick that arrives while the count is 0 is an expiry and reloads the count from reload, so one period lasts reload+1 ticks. The live count reads 0 between the tick that brings it to zero and the expiry tick.
- R7: An expiry sets the flag. A control read returns the flag and then clears it.
- R8: irq_o pulses for one cycle after an expiry only when the interrupt enable is set.
- R9: An expiry with reload equal to 0 clears the enable bit, so counting stops.
- R10: Clearing the enable freezes the count, and the live count reads 0 while the timer is disabled. Setting the enable again resumes from the frozen count.
- R11: Setting the enable when no count is in progress (after reset, or after the stop described in R9) first loads the count from reload.
- R12: Any write to the live count slot restarts the count from reload and clears the flag. Such a write takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | External reference tick, one-cycle pulse |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register slot |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | One-cycle pending request on expiry |

## Verification
A wrong internal count shows up on the live count read in the cycle after the read request, so the checks read the count after each controlled reference tick. A flag that is set or cleared at the wrong time shows up on the next control read, which is why the checks read control twice in a row. A missing or unwanted interrupt pulse shows in a running count of irq_o pulses, which is compared after each expiry. An armed state that is out of step shows only when the timer is turned on again, so the checks read the live count right after each enable write, both with and without a count in progress.

// File: rtl/systick_pkg.sv
package systick_pkg;
  typedef enum logic [1:0] {
    CSR_CTRL    = 2'd0,
    CSR_RELOAD  = 2'd1,
    CSR_CURRENT = 2'd2,
    CSR_CALIB   = 2'd3
  } csr_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IRQ_BIT  = 1;
  localparam int unsigned CTRL_SRC_BIT  = 2;
  localparam int unsigned CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/systick_src_sel.sv
module systick_src_sel (
  input  logic use_core_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  // Core clock source: every cycle is a tick; otherwise follow the pulse.
  assign tick_o = use_core_i ? 1'b1 : ref_tick_i;
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_i & tick_i & ~restart_i & at_zero;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= reload_i;
      armed_q <= 1'b1;
    end else if (arm_i && !armed_q) begin
      cnt_q   <= reload_i;
      armed_q <= 1'b1;
    end else if (run_i && tick_i) begin
      if (at_zero) begin
        cnt_q <= reload_i;
        if (reload_i == '0) armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !restart_i && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !restart_i && at_zero) |=> cnt_q == $past(reload_i));

  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i && !arm_i) |=> $stable(cnt_q));

  p_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CALIB_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              restart_o,
  output logic              arm_o,
  output logic              irq_o
);
  csr_e              sel;
  ctrl_t             ctrl_q;
  logic              flag_q;
  logic [CNT_W-1:0]  reload_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_val;
  logic              wr_ctrl, rd_ctrl, wr_reload, wr_cur, rd_any;
  logic              unused_wdata;

  assign sel       = csr_e'(addr_i);
  assign rd_any    = req_i & ~we_i;
  assign wr_ctrl   = req_i & we_i & (sel == CSR_CTRL);
  assign rd_ctrl   = rd_any & (sel == CSR_CTRL);
  assign wr_reload = req_i & we_i & (sel == CSR_RELOAD);
  assign wr_cur    = req_i & we_i & (sel == CSR_CURRENT);
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign restart_o = wr_cur;
  assign arm_o     = wr_ctrl & wdata_i[CTRL_EN_BIT] & ~ctrl_q.en;
  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign irq_o     = irq_q;

  always_comb begin
    rd_val = '0;
    unique case (sel)
      CSR_CTRL: begin
        rd_val[CTRL_FLAG_BIT] = flag_q;
        rd_val[CTRL_EN_BIT]   = ctrl_q.en;
        rd_val[CTRL_IRQ_BIT]  = ctrl_q.irq_en;
        rd_val[CTRL_SRC_BIT]  = ctrl_q.src_core;
      end
      CSR_RELOAD:  rd_val[CNT_W-1:0] = reload_q;
      CSR_CURRENT: rd_val[CNT_W-1:0] = ctrl_q.en ? cnt_i : '0;
      default:     rd_val = DATA_W'(CALIB_VAL);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= ctrl_t'(wdata_i[CTRL_SRC_BIT:CTRL_EN_BIT]);
      else if (expire_i && reload_q == '0)
        ctrl_q.en <= 1'b0;

      if (expire_i)                flag_q <= 1'b1;
      else if (rd_ctrl || wr_cur)  flag_q <= 1'b0;

      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];

      rvalid_q <= rd_any;
      if (rd_any) rdata_q <= rd_val;

      irq_q <= expire_i & ctrl_q.irq_en;
    end
  end

  p_autodis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && reload_q == '0 && !wr_ctrl) |=> !ctrl_q.en);

  p_flag_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !expire_i) |=> flag_q == $past(flag_q));

  p_irq_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag_q);

  p_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_q && $past(addr_i) != 2'd0) |-> rdata_q[DATA_W-1:CNT_W] == '0);
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CALIB_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             tick, restart, arm, expire;

  systick_src_sel u_src (
    .use_core_i (ctrl.src_core),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl.en),
    .tick_i    (tick),
    .restart_i (restart),
    .arm_i     (arm),
    .reload_i  (reload),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  systick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_VAL)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .expire_i  (expire),
    .rvalid_o  (rvalid_o),
    .rdata_o   (rdata_o),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .restart_o (restart),
    .arm_o     (arm),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/systick_timer_tb_top.sv
module systick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  systick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // Monitor: pops the scoreboard as responses arrive.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected response 0x%08h expected none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
    if (rst_n && irq) irq_cnt++;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rvalid at reset", {31'b0, rvalid}, 32'd0);
    chk("R1 irq at reset", {31'b0, irq}, 32'd0);
    rd(2'd0, 32'h0, "R1 ctrl reset");
    rd(2'd1, 32'h0, "R1 reload reset");
    rd(2'd2, 32'h0, "R1 current reset");
    rd(2'd3, 32'd10000, "R1 R2 calibration");
    // R4 upper bits dropped
    wr(2'd1, 32'hFF00_0003);
    rd(2'd1, 32'h3, "R4 reload upper ignored");
    // R3 R11 enable with flag write attempt, fresh load
    wr(2'd0, 32'h0001_0003);
    rd(2'd0, 32'h3, "R3 flag not writable");
    rd(2'd2, 32'h3, "R11 fresh enable loads reload");
    tick();
    rd(2'd2, 32'h2, "R5 one tick decrements");
    tick(); tick();
    rd(2'd2, 32'h0, "R6 reads zero before expiry");
    rd(2'd0, 32'h3, "R6 no expiry yet");
    tick();
    rd(2'd0, 32'h0001_0003, "R7 flag set on expiry");
    rd(2'd0, 32'h3, "R7 flag cleared by read");
    rd(2'd2, 32'h3, "R6 reload after expiry");
    chk("R8 irq on expiry", irq_cnt, 1);
    // R10 freeze and resume
    tick();
    wr(2'd0, 32'h2);
    rd(2'd2, 32'h0, "R10 reads zero disabled");
    tick();
    wr(2'd0, 32'h3);
    rd(2'd2, 32'h2, "R10 resume frozen count");
    // R12 restart clears flag
    tick(); tick(); tick();
    tick();
    wr(2'd2, 32'h55);
    rd(2'd0, 32'h3, "R12 write current clears flag");
    rd(2'd2, 32'h3, "R12 restart from reload");
    chk("R8 second irq", irq_cnt, 2);
    // R8 irq disabled
    wr(2'd0, 32'h1);
    tick(); tick(); tick(); tick();
    rd(2'd0, 32'h0001_0001, "R8 flag without irq");
    chk("R8 no irq when disabled", irq_cnt, 2);
    // R9 zero reload stops timer
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    tick();
    rd(2'd0, 32'h0001_0000, "R9 enable cleared");
    rd(2'd2, 32'h0, "R9 current zero");
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h1);
    rd(2'd2, 32'h2, "R11 reload after auto stop");
    // R5 core clock source
    wr(2'd1, 32'h9);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h5);
    rd(2'd2, 32'h9, "R5 core clock first");
    rd(2'd2, 32'h8, "R5 core clock every cycle");
    repeat (12) @(negedge clk);
    rd(2'd0, 32'h0001_0005, "R6 core clock expiry");
    repeat (3) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule